// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block keeps time of day and date as a chain of cascaded BCD counters: hundredths of a second, seconds, minutes and 24-hour hours, then day of month, month, a two-bit year-in-cycle field, weekday and a day timer. Each day rollover advances the calendar. The calendar repeats every four years, and the year whose cycle field is 0 is the leap year. A single input, `src_tick`, drives the chain, and the mode field of the control byte says how to use it. In oscillator mode a fractional divider turns `OSC_HZ` source pulses into `TICK_HZ` hundredths steps. In 50 Hz mode each source pulse adds two hundredths. In event mode each pulse advances a six-digit BCD count held in bytes 1 to 3.

A host reaches the state through a plain register port. A write changes exactly one byte on the next clock edge. A one-cycle `rd_start` strobe copies all seven counter bytes into a capture bank, and `rd_data` shows the captured byte chosen by `rd_addr`. A multi-byte read therefore always sees one consistent instant, even when a carry ripples through the chain while the bytes are being read. Byte 0 is the control byte and reads back live. The port has no streaming data, so it carries no valid/ready handshake and never applies back-pressure.

Top module: `rtc_counter_chain`

## Requirements
- R1: Byte 0 holds the mode in bits [1:0]: 0 oscillator clock, 1 50 Hz clock, 2 event counter, 3 halted. Bits [7:2] read as zero, and a written mode reads back unchanged.
- R2: In oscillator mode, with the divider at reset, the hundredths byte (address 1) is still 00 after 327 source pulses and becomes 01 on the 328th. Exactly `TICK_HZ` hundredths steps occur every `OSC_HZ` pulses, so 32768 pulses leave hundredths at 00 and seconds (address 2) at 01.
- R3: In 50 Hz mode, each source pulse adds 2 to the BCD hundredths. Reaching 100 wraps it by subtracting 100 and carries one second.
- R4: Seconds (address 2) and minutes (address 3) wrap after 59, and hours (address 4) wrap after 23, each to 00 with a carry onward. A value at or above its maximum, including a non-decimal one, wraps the same way.
- R5: Address 5 holds the year-in-cycle in bits [7:6] and the BCD date in [5:0]. Address 6 holds the weekday in bits [7:5] and the BCD month in [4:0]. On a day rollover the date wraps to 01 after the month's last day, where February has 29 days only when the year field is 0. Month 12 wraps to 01 and the year field advances modulo 4.
- R6: On each day rollover the weekday advances and wraps from 6 to 0, and the BCD day timer at address 7 advances and wraps from 99 to 00.
- R7: In event mode each source pulse increments the six-digit BCD value formed by addresses 3, 2 and 1 (most significant first), with 999999 wrapping to 000000. Addresses 4 to 7 do not change.
- R8: A `rd_start` pulse captures all seven counter bytes. `rd_data` for addresses 1 to 7 returns the captured value, which holds until the next pulse.
- R9: A write changes only the addressed byte, and the write wins over a carry arriving at that byte in the same cycle.
- R10: In halted mode, source pulses change no counter.
- R11: After reset the mode is 0, addresses 1 to 4 and 7 read 00, and addresses 5 and 6 read 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | One-cycle source pulse (oscillator, 50 Hz or event) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_start | input | 1 | One-cycle strobe that captures all counters |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Captured byte, or live control byte at address 0 |

## Verification
In 50 Hz mode and event mode the bench steps single pulses and compares each captured count with the value computed from the pulse number. These sweeps separate a BCD carry error from a wrong step size. A sweep over every month of all four cycle years, each started at the month's last day at 23:59:59.98, tells leap handling apart from month-length errors and from year-advance errors. Other runs check the divider's first step and its one-second total, out-of-range values, a write colliding with a carry, the capture bank holding while counting continues, and halted mode.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    MODE_OSC   = 2'd0,
    MODE_50HZ  = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_HALT  = 2'd3
  } mode_e;

  // element i holds byte address i+1
  typedef logic [6:0][7:0] cnt_file_t;

  localparam cnt_file_t CNT_RST = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  // {carry, next bcd}: at or beyond maxv wraps to minv
  function automatic logic [8:0] inc_wrap(input logic [7:0] bcd, input logic [7:0] maxv,
                                          input logic [7:0] minv);
    logic [7:0] v;
    v = bcd2bin(bcd);
    if (v >= maxv) return {1'b1, bin2bcd(minv)};
    return {1'b0, bin2bcd(v + 8'd1)};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] month, input logic leap);
    case (month)
      8'd2: return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default: return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_pkg::*;
#(
  parameter int OSC_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic       src_tick,
  output logic [1:0] step,
  output logic       evt_inc
);
  localparam int ACC_W   = $clog2(OSC_HZ + TICK_HZ);
  localparam int MAX_GAP = (OSC_HZ - 1) / TICK_HZ;

  logic [ACC_W-1:0] acc_q, acc_sum, gap_q;
  logic             wrap, osc_pulse;

  assign acc_sum   = acc_q + ACC_W'(TICK_HZ);
  assign wrap      = acc_sum >= ACC_W'(OSC_HZ);
  assign osc_pulse = (mode == MODE_OSC) && src_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (osc_pulse) acc_q <= wrap ? acc_sum - ACC_W'(OSC_HZ) : acc_sum;
  end

  always_comb begin
    case (mode)
      MODE_OSC:  step = {1'b0, src_tick & wrap};
      MODE_50HZ: step = src_tick ? 2'd2 : 2'd0;
      default:   step = 2'd0;
    endcase
  end

  assign evt_inc = (mode == MODE_EVENT) && src_tick;

  // source pulses since the last hundredths step
  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= '0;
    else if (osc_pulse) gap_q <= (step != 2'd0) ? '0 : gap_q + 1'b1;
  end

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= ACC_W'(MAX_GAP)); // R2
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  cnt_file_t  cur,
  input  logic [1:0] step,
  input  logic       evt_inc,
  output cnt_file_t  nxt,
  output logic       hund_carry,
  output logic       day_carry
);
  logic [8:0] r_e0, r_e1, r_e2, r_s, r_m, r_h, r_d, r_mo, r_t;
  logic [7:0] hb, dim;
  logic [2:0] wd;

  always_comb begin
    nxt        = cur;
    hund_carry = 1'b0;
    day_carry  = 1'b0;
    r_e0 = inc_wrap(cur[0], 8'd99, 8'd0);
    r_e1 = inc_wrap(cur[1], 8'd99, 8'd0);
    r_e2 = inc_wrap(cur[2], 8'd99, 8'd0);
    hb   = bcd2bin(cur[0]) + {6'b0, step};
    r_s  = inc_wrap(cur[1], 8'd59, 8'd0);
    r_m  = inc_wrap(cur[2], 8'd59, 8'd0);
    r_h  = inc_wrap(cur[3], 8'd23, 8'd0);
    dim  = month_days(bcd2bin({3'b0, cur[5][4:0]}), cur[4][7:6] == 2'd0);
    r_d  = inc_wrap({2'b0, cur[4][5:0]}, dim, 8'd1);
    r_mo = inc_wrap({3'b0, cur[5][4:0]}, 8'd12, 8'd1);
    r_t  = inc_wrap(cur[6], 8'd99, 8'd0);
    wd   = (cur[5][7:5] >= 3'd6) ? 3'd0 : cur[5][7:5] + 3'd1;

    if (evt_inc) begin
      nxt[0] = r_e0[7:0];
      if (r_e0[8]) begin
        nxt[1] = r_e1[7:0];
        if (r_e1[8]) nxt[2] = r_e2[7:0];
      end
    end else if (step != 2'd0) begin
      if (hb >= 8'd100) begin
        hund_carry = 1'b1;
        nxt[0]     = bin2bcd(hb - 8'd100);
      end else begin
        nxt[0] = bin2bcd(hb);
      end
      if (hund_carry) begin
        nxt[1] = r_s[7:0];
        if (r_s[8]) begin
          nxt[2] = r_m[7:0];
          if (r_m[8]) begin
            nxt[3]    = r_h[7:0];
            day_carry = r_h[8];
          end
        end
      end
      if (day_carry) begin
        nxt[4] = {cur[4][7:6] + {1'b0, r_d[8] & r_mo[8]}, 6'(r_d[7:0])};
        nxt[5] = {wd, r_d[8] ? 5'(r_mo[7:0]) : cur[5][4:0]};
        nxt[6] = r_t[7:0];
      end
    end
  end
endmodule

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain
  import rtc_pkg::*;
#(
  parameter int OSC_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_start,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int NCNT = 7;

  mode_e      mode_q;
  cnt_file_t  cnt_q, cnt_nxt, cap_q;
  logic [1:0] step;
  logic       evt_inc, hund_carry, day_carry;

  rtc_tick_gen #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .src_tick(src_tick),
    .step(step), .evt_inc(evt_inc)
  );

  rtc_advance u_adv (
    .cur(cnt_q), .step(step), .evt_inc(evt_inc),
    .nxt(cnt_nxt), .hund_carry(hund_carry), .day_carry(day_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OSC;
    else if (wr_en && wr_addr == 3'd0) mode_q <= mode_e'(wr_data[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else begin
      for (int i = 0; i < NCNT; i++)
        cnt_q[i] <= (wr_en && wr_addr == 3'(i + 1)) ? wr_data : cnt_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cap_q <= CNT_RST;
    else if (rd_start) cap_q <= cnt_q;
  end

  assign rd_data = (rd_addr == 3'd0) ? {6'b0, mode_q} : cap_q[3'(rd_addr - 3'd1)];

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(cap_q)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 3'd0) |=> cnt_q[3'($past(wr_addr) - 3'd1)] == $past(wr_data)); // R9
  AST_HALT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HALT && !wr_en) |=> $stable(cnt_q)); // R10
  AST_EVT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EVENT && !wr_en) |=> cnt_q[6:3] == $past(cnt_q[6:3])); // R7
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_carry && cnt_q[1] == 8'h59 && !(wr_en && wr_addr == 3'd2)) |=> cnt_q[1] == 8'h00); // R4
  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && cnt_q[5][7:5] == 3'd6 && !(wr_en && wr_addr == 3'd6)) |=> cnt_q[5][7:5] == 3'd0); // R6
endmodule

// File: tb/rtc_counter_chain_bench.sv
`timescale 1ns/1ps
module rtc_counter_chain_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, src_tick = 1'b0, wr_en = 1'b0, rd_start = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;

  rtc_counter_chain u_rtc_counter_chain (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_start(rd_start), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] tobcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int m, input bit leap);
    case (m)
      2: return leap ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_start = 1'b0; src_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    src_tick = 1'b1;
    repeat (n) @(negedge clk);
    src_tick = 1'b0;
  endtask

  task automatic snap();
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] got;
    rd_addr = a;
    #1 got = rd_data;
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr %0d got %h expected %h", req, a, got, exp);
    end
    @(negedge clk);
  endtask

  task automatic day_edge(input logic [7:0] date_b, input logic [7:0] mon_b);
    wr(3'd4, 8'h23); wr(3'd3, 8'h59); wr(3'd2, 8'h59); wr(3'd1, 8'h98);
    wr(3'd5, date_b); wr(3'd6, mon_b);
    ticks(1);
    snap();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11", 3'd0, 8'h00);
    for (int a = 1; a <= 7; a++) chk("R11", 3'(a), (a == 5 || a == 6) ? 8'h01 : 8'h00);
    // R1 control readback
    wr(3'd0, 8'h02); chk("R1", 3'd0, 8'h02);
    wr(3'd0, 8'hFD); chk("R1", 3'd0, 8'h01);

    // R2 fractional divider
    do_reset();
    ticks(327); snap(); chk("R2", 3'd1, 8'h00);
    ticks(1);   snap(); chk("R2", 3'd1, 8'h01);
    do_reset();
    ticks(32768); snap(); chk("R2", 3'd1, 8'h00); chk("R2", 3'd2, 8'h01);

    // R3 50 Hz sweep
    do_reset(); wr(3'd0, 8'h01);
    for (int k = 1; k <= 60; k++) begin
      ticks(1); snap();
      chk("R3", 3'd1, tobcd((2 * k) % 100));
      chk("R3", 3'd2, tobcd((2 * k) / 100));
    end

    // R4 wraps, full cascade and out-of-range value
    do_reset(); wr(3'd0, 8'h01);
    day_edge(8'h10, 8'h05);
    for (int a = 1; a <= 4; a++) chk("R4", 3'(a), 8'h00);
    wr(3'd4, 8'h05); wr(3'd3, 8'h59); wr(3'd2, 8'h59); wr(3'd1, 8'h98);
    ticks(1); snap();
    chk("R4", 3'd3, 8'h00); chk("R4", 3'd4, 8'h06);
    wr(3'd3, 8'h10); wr(3'd2, 8'h75); wr(3'd1, 8'h98);
    ticks(1); snap();
    chk("R4", 3'd2, 8'h00); chk("R4", 3'd3, 8'h11);

    // R5 month ends over the whole four-year cycle
    do_reset(); wr(3'd0, 8'h01);
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        logic [7:0] db, mb, nmb;
        int ny, nm;
        db  = tobcd(mdays(m, y == 0));
        mb  = tobcd(m);
        nm  = (m == 12) ? 1 : m + 1;
        ny  = (m == 12) ? (y + 1) % 4 : y;
        nmb = tobcd(nm);
        day_edge({2'(y), db[5:0]}, {3'd0, mb[4:0]});
        chk("R5", 3'd5, {2'(ny), 6'h01});
        chk("R5", 3'd6, {3'd1, nmb[4:0]});
      end
    end
    day_edge({2'd0, 6'h28}, {3'd0, 5'h02});
    chk("R5", 3'd5, 8'h29); chk("R5", 3'd6, 8'h22);

    // R6 weekday and day timer
    do_reset(); wr(3'd0, 8'h01); wr(3'd7, 8'h99);
    day_edge(8'h10, {3'd6, 5'h05});
    chk("R6", 3'd6, 8'h05); chk("R6", 3'd5, 8'h11); chk("R6", 3'd7, 8'h00);
    wr(3'd7, 8'h41);
    day_edge(8'h11, 8'h05);
    chk("R6", 3'd7, 8'h42); chk("R6", 3'd6, 8'h25);

    // R7 event counter
    do_reset(); wr(3'd4, 8'h12); wr(3'd7, 8'h55); wr(3'd0, 8'h02);
    for (int k = 1; k <= 150; k++) begin
      ticks(1); snap();
      chk("R7", 3'd1, tobcd(k % 100));
      chk("R7", 3'd2, tobcd(k / 100));
    end
    wr(3'd1, 8'h99); wr(3'd2, 8'h99); wr(3'd3, 8'h99);
    ticks(1); snap();
    chk("R7", 3'd1, 8'h00); chk("R7", 3'd2, 8'h00); chk("R7", 3'd3, 8'h00);
    chk("R7", 3'd4, 8'h12); chk("R7", 3'd7, 8'h55);

    // R8 capture holds until the next strobe
    do_reset(); wr(3'd0, 8'h01);
    ticks(3); snap(); chk("R8", 3'd1, 8'h06);
    ticks(5); chk("R8", 3'd1, 8'h06);
    snap(); chk("R8", 3'd1, 8'h16);

    // R9 write beats a same-cycle carry; single-byte isolation
    do_reset(); wr(3'd0, 8'h01); wr(3'd1, 8'h98); wr(3'd2, 8'h10);
    src_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h33;
    @(negedge clk);
    src_tick = 1'b0; wr_en = 1'b0;
    wr(3'd3, 8'h45);
    snap();
    chk("R9", 3'd1, 8'h00); chk("R9", 3'd2, 8'h33); chk("R9", 3'd3, 8'h45);
    chk("R9", 3'd4, 8'h00); chk("R9", 3'd5, 8'h01); chk("R9", 3'd6, 8'h01); chk("R9", 3'd7, 8'h00);

    // R10 halted
    do_reset(); wr(3'd0, 8'h03); wr(3'd1, 8'h42);
    ticks(50); snap();
    chk("R10", 3'd1, 8'h42); chk("R10", 3'd2, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule